// File: doc/BRIEF.md
# Performance Monitoring Counter Unit

This block counts processor activity for profiling. It holds one 32-bit cycle counter and four 32-bit event counters. Each event counter takes its source from a vector of single-cycle event pulses, and an 8-bit code picks the source. All four codes sit in one packed select word. A simple register port gives access to the control word, the select word, the interrupt mask, the overflow flags and the five counters. Writes take effect at the clock edge. Reads return data one clock after the address is presented.

For sampled profiling, software writes the two's complement of a period N into a counter. After N counted events the counter wraps from all ones to zero and sets its overflow flag. It then keeps counting from zero. A level interrupt stays high while any flag whose mask bit is set is pending. Software clears a flag by writing a one to its bit. The control word also holds two self-clearing reset strobes, one for the event counters and one for the cycle counter, and a mode bit that slows the cycle counter to one step every 64 clocks.

Top module: `perf_counter_unit`

## Requirements
- R1: After a synchronous reset, every register reads zero, except the select word, which reads 0xFFFFFFFF so that no counter has a source. The interrupt is low.
- R2: Control bit 0 gates all counting. While it is set and bit 3 is clear, the cycle counter adds one on every clock. While it is clear, no counter changes except through a write or a reset strobe.
- R3: With control bit 3 set, the cycle counter adds one on every 64th enabled clock. The divider keeps its phase while counting is disabled.
- R4: Writing control bit 1 zeroes the four event counters. Writing control bit 2 zeroes the cycle counter and restarts the divider. Neither strobe touches the other counters or the flags, and both bits read back as zero.
- R5: A control read returns bit 0 (enable) and bit 3 (divide mode) and zero in every other bit. Writes to bits 4 to 31 have no effect.
- R6: Event counter i takes its code from select-word bits 8i+7:8i. It adds one on each enabled clock where the event input line numbered by that code is high.
- R7: A code above 0x16, a code with no matching input line, and code 0xFF each count nothing.
- R8: Every counter can be written directly. When a write and an increment hit the same counter in the same clock, the written value is kept.
- R9: A counter that steps from 0xFFFFFFFF to 0 sets its overflow flag and keeps counting from zero. The cycle counter uses flag bit 0 and event counter i uses flag bit i+1. A preset of minus N sets the flag on the Nth counted event.
- R10: Flags stay set until software writes a one to that bit. Writing zero leaves a flag unchanged.
- R11: The interrupt mask uses the same bit map as the flags. The interrupt output rises one clock after a masked-in flag is pending and falls one clock after no such flag remains.
- R12: Read data is registered. The value appears one clock after the address and shows the register's contents before that clock edge. Register map: 0 control, 1 select word, 2 interrupt mask, 3 flags, 4 cycle counter, 5 to 8 event counters 0 to 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 4 | Register address, used for both writes and reads |
| reg_wdata | input | 32 | Write data |
| evt_in | input | 23 | Single-cycle event pulses, one line per event code |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt |

## Verification
The checker runs on every cycle. It checks that a flag only falls after a write of one to its bit, that the interrupt follows the masked flags with exactly one clock of delay, that the cycle counter holds while counting is disabled and steps by one per clock in normal mode, that the event strobe empties the event counters, and the post-reset state. The bench scenarios are the only place that shows the mapping from codes and select-word fields to input lines, that out-of-range codes are rejected, the divide-by-64 phase across a pause, write priority over increment, wrap-around with preset periods, and the read-back view of the control word.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int ADDR_W = 4;
  localparam int REG_W  = 32;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 4'd0,
    A_EVSEL = 4'd1,
    A_IEN   = 4'd2,
    A_FLAG  = 4'd3,
    A_CCNT  = 4'd4,
    A_EV0   = 4'd5
  } pmu_addr_e;

  localparam int CTRL_EN     = 0;
  localparam int CTRL_RST_EV = 1;
  localparam int CTRL_RST_CY = 2;
  localparam int CTRL_DIV    = 3;
endpackage

// File: rtl/pmu_prescaler.sv
module pmu_prescaler #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [PW-1:0] phase;

  assign tick = run && (phase == PW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) phase <= '0;
    else if (run)   phase <= tick ? '0 : phase + 1'b1;
  end
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  // load beats increment; a wrap only counts when the increment lands
  assign wrap = inc && !load && !clr && (&cnt);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (load)  cnt <= load_val;
    else if (inc)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pmu_evt_sel.sv
module pmu_evt_sel #(
  parameter int CODE_W   = 8,
  parameter int NUM_EVT  = 23,
  parameter int MAX_CODE = 22
) (
  input  logic [CODE_W-1:0]  code,
  input  logic [NUM_EVT-1:0] evt,
  output logic               hit
);
  always_comb begin
    hit = 1'b0;
    for (int k = 0; k < NUM_EVT; k++) begin
      if (k <= MAX_CODE && code == CODE_W'(k)) hit = evt[k];
    end
  end
endmodule

// File: rtl/perf_counter_unit.sv
module perf_counter_unit
  import pmu_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int NUM_CNT  = 4,
  parameter int CODE_W   = 8,
  parameter int NUM_EVT  = 23,
  parameter int MAX_CODE = 22,
  parameter int PRESCALE = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  input  logic [NUM_EVT-1:0] evt_in,
  output logic [REG_W-1:0]   reg_rdata,
  output logic               irq
);
  localparam int NF    = NUM_CNT + 1;
  localparam int SEL_W = NUM_CNT * CODE_W;

  logic                           en_q, div_q;
  logic [SEL_W-1:0]               evsel_q;
  logic [NF-1:0]                  ie_q, flags_q, wrap;
  logic [CNT_W-1:0]               ccnt;
  logic [NUM_CNT-1:0][CNT_W-1:0]  evcnt;
  logic                           pre_tick, cy_inc;
  logic [REG_W-1:0]               rd_mux;

  wire wr_ctrl = reg_wr && reg_addr == A_CTRL;
  wire wr_sel  = reg_wr && reg_addr == A_EVSEL;
  wire wr_ien  = reg_wr && reg_addr == A_IEN;
  wire wr_flag = reg_wr && reg_addr == A_FLAG;
  wire wr_cy   = reg_wr && reg_addr == A_CCNT;
  wire clr_ev  = wr_ctrl && reg_wdata[CTRL_RST_EV];
  wire clr_cy  = wr_ctrl && reg_wdata[CTRL_RST_CY];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      div_q   <= 1'b0;
      evsel_q <= '1;
      ie_q    <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q  <= reg_wdata[CTRL_EN];
        div_q <= reg_wdata[CTRL_DIV];
      end
      if (wr_sel) evsel_q <= reg_wdata[SEL_W-1:0];
      if (wr_ien) ie_q    <= reg_wdata[NF-1:0];
    end
  end

  pmu_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk(clk), .rst(rst), .clr(clr_cy), .run(en_q && div_q), .tick(pre_tick)
  );

  assign cy_inc = en_q && (!div_q || pre_tick);

  pmu_counter #(.W(CNT_W)) u_cy (
    .clk(clk), .rst(rst), .clr(clr_cy), .load(wr_cy),
    .load_val(reg_wdata[CNT_W-1:0]), .inc(cy_inc), .cnt(ccnt), .wrap(wrap[0])
  );

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_ev
    logic hit;
    wire  wr_this = reg_wr && reg_addr == ADDR_W'(int'(A_EV0) + g);

    pmu_evt_sel #(.CODE_W(CODE_W), .NUM_EVT(NUM_EVT), .MAX_CODE(MAX_CODE)) u_sel (
      .code(evsel_q[g*CODE_W +: CODE_W]), .evt(evt_in), .hit(hit)
    );

    pmu_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .clr(clr_ev), .load(wr_this),
      .load_val(reg_wdata[CNT_W-1:0]), .inc(en_q && hit),
      .cnt(evcnt[g]), .wrap(wrap[g+1])
    );
  end

  // a wrap in the same clock as a clearing write keeps the flag set
  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      irq     <= 1'b0;
    end else begin
      flags_q <= (flags_q & ~(wr_flag ? reg_wdata[NF-1:0] : NF'(0))) | wrap;
      irq     <= |(flags_q & ie_q);
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      A_CTRL: begin
        rd_mux[CTRL_EN]  = en_q;
        rd_mux[CTRL_DIV] = div_q;
      end
      A_EVSEL: rd_mux = REG_W'(evsel_q);
      A_IEN:   rd_mux = REG_W'(ie_q);
      A_FLAG:  rd_mux = REG_W'(flags_q);
      A_CCNT:  rd_mux = REG_W'(ccnt);
      default: begin
        for (int i = 0; i < NUM_CNT; i++) begin
          if (reg_addr == ADDR_W'(int'(A_EV0) + i)) rd_mux = REG_W'(evcnt[i]);
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/perf_counter_unit_chk.sv
module perf_counter_unit_chk
  import pmu_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int NUM_CNT = 4
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          reg_wr,
  input logic [ADDR_W-1:0]             reg_addr,
  input logic [REG_W-1:0]              reg_wdata,
  input logic                          irq,
  input logic                          en,
  input logic                          div,
  input logic [CNT_W-1:0]              ccnt,
  input logic [NUM_CNT-1:0][CNT_W-1:0] evcnt,
  input logic [NUM_CNT:0]              flags,
  input logic [NUM_CNT:0]              ie
);
  logic rst_q = 1'b0;
  wire  wr_cy_any = reg_wr && (reg_addr == A_CCNT ||
                    (reg_addr == A_CTRL && reg_wdata[CTRL_RST_CY]));

  always @(posedge clk) begin
    rst_q <= rst;
    if (rst_q && !rst) begin
      // R1
      reset_state_chk: assert (flags == '0 && ie == '0 && ccnt == '0 &&
                               evcnt == '0 && !irq && !en)
        else $error("reset state wrong");
    end
  end

  for (genvar b = 0; b <= NUM_CNT; b++) begin : g_flag
    // R10
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(flags[b]) |-> $past(reg_wr && reg_addr == A_FLAG && reg_wdata[b]));
  end

  // R11
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    irq == $past(|(flags & ie)));

  // R2
  cycle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !wr_cy_any) |=> $stable(ccnt));

  // R2
  cycle_step_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !div && !wr_cy_any) |=> ccnt == $past(ccnt) + 1'b1);

  // R4
  event_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == A_CTRL && reg_wdata[CTRL_RST_EV]) |=> evcnt == '0);
endmodule

bind perf_counter_unit perf_counter_unit_chk #(.CNT_W(CNT_W), .NUM_CNT(NUM_CNT)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .irq(irq), .en(en_q), .div(div_q), .ccnt(ccnt), .evcnt(evcnt),
  .flags(flags_q), .ie(ie_q)
);

// File: tb/sim_perf_counter_unit.sv
`timescale 1ns/1ps
module sim_perf_counter_unit;
  import pmu_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [22:0] evt_in = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  perf_counter_unit u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .evt_in(evt_in), .reg_rdata(reg_rdata), .irq(irq)
  );

  typedef struct packed {
    logic [1:0] cnt;
    logic [7:0] code;
    logic [4:0] line;
    logic [7:0] pulses;
    logic [7:0] exp;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'd0, 8'h05, 5'd5,  8'd10, 8'd10},
    '{2'd1, 8'h07, 5'd7,  8'd3,  8'd3},
    '{2'd2, 8'h07, 5'd5,  8'd4,  8'd0},
    '{2'd3, 8'h16, 5'd22, 8'd6,  8'd6},
    '{2'd0, 8'h20, 5'd0,  8'd5,  8'd0},
    '{2'd1, 8'hFF, 5'd22, 8'd4,  8'd0},
    '{2'd2, 8'h00, 5'd0,  8'd8,  8'd8},
    '{2'd3, 8'h17, 5'd22, 8'd3,  8'd0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // caller sits at a negedge; the write lands on the next posedge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int line);
    evt_in = 23'(1) << line;
    @(negedge clk);
    evt_in = '0;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state of every register
    for (int a = 0; a < 9; a++) begin
      rd(4'(a), v);
      chk($sformatf("R1 reset addr %0d", a), v, (a == 1) ? 32'hFFFF_FFFF : 32'h0);
    end
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);

    // R2 normal cycle count: 10 counted edges
    wr(A_CTRL, 32'h4);
    wr(A_CTRL, 32'h1);
    idle(9);
    wr(A_CTRL, 32'h0);
    rd(A_CCNT, v); chk("R2 cycle count", v, 32'd10);
    rd(A_CCNT, v); chk("R2 no count while disabled", v, 32'd10);

    // R3 divide-by-64: 191 enabled edges give 2 steps
    wr(A_CTRL, 32'hD);
    idle(190);
    wr(A_CTRL, 32'h8);
    rd(A_CCNT, v); chk("R3 divided count", v, 32'd2);
    wr(A_CTRL, 32'h9);
    wr(A_CTRL, 32'h8);
    rd(A_CCNT, v); chk("R3 phase kept across pause", v, 32'd3);
    // R4 cycle strobe restarts the divider
    wr(A_CTRL, 32'hC);
    wr(A_CTRL, 32'h9);
    idle(62);
    wr(A_CTRL, 32'h8);
    rd(A_CCNT, v); chk("R4 divider restarted", v, 32'd0);
    wr(A_CTRL, 32'h0);

    // R6 R7 table of code / line / pulse vectors
    foreach (VECS[i]) begin
      logic [31:0] sel;
      sel = 32'hFFFF_FFFF;
      sel[VECS[i].cnt*8 +: 8] = VECS[i].code;
      wr(A_CTRL, 32'h2);
      wr(A_EVSEL, sel);
      wr(A_CTRL, 32'h1);
      for (int p = 0; p < int'(VECS[i].pulses); p++) pulse(int'(VECS[i].line));
      wr(A_CTRL, 32'h0);
      rd(4'(int'(A_EV0) + int'(VECS[i].cnt)), v);
      chk($sformatf("R6/R7 vector %0d code %h", i, VECS[i].code), v, 32'(VECS[i].exp));
    end

    // R8 write wins over a same-clock increment
    wr(A_CTRL, 32'h2);
    wr(A_EVSEL, 32'hFFFF_FF00);
    evt_in = 23'h1;
    wr(A_CTRL, 32'h1);
    wr(A_EV0, 32'h100);
    wr(A_CTRL, 32'h0);
    evt_in = '0;
    rd(A_EV0, v); chk("R8 write priority", v, 32'h101);
    wr(4'(int'(A_EV0) + 1), 32'h1234_5678);
    rd(4'(int'(A_EV0) + 1), v); chk("R8 direct write", v, 32'h1234_5678);
    wr(A_CCNT, 32'h55);

    // R4 strobes
    wr(A_CTRL, 32'h2);
    rd(4'(int'(A_EV0) + 1), v); chk("R4 event strobe clears", v, 32'h0);
    rd(A_CCNT, v); chk("R4 event strobe spares cycle counter", v, 32'h55);
    rd(A_CTRL, v); chk("R4 strobes read zero", v, 32'h0);
    wr(A_CTRL, 32'h4);
    rd(A_CCNT, v); chk("R4 cycle strobe clears", v, 32'h0);

    // R5 control read view
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, v); chk("R5 control view", v, 32'h9);
    wr(A_CTRL, 32'h0);

    // R9 preset -3 on event counter 2, code 7
    wr(A_EVSEL, 32'hFF07_FFFF);
    wr(4'(int'(A_EV0) + 2), 32'hFFFF_FFFD);
    wr(A_IEN, 32'h08);
    wr(A_CTRL, 32'h1);
    pulse(7); pulse(7);
    rd(A_FLAG, v); chk("R9 no flag before period", v, 32'h0);
    evt_in = 23'(1) << 7;
    @(negedge clk);
    chk("R11 irq lags flag", {31'b0, irq}, 32'h0);
    evt_in = '0;
    @(negedge clk);
    chk("R11 irq raised", {31'b0, irq}, 32'h1);
    pulse(7);
    wr(A_CTRL, 32'h0);
    rd(4'(int'(A_EV0) + 2), v); chk("R9 counts on after wrap", v, 32'h1);
    // R9 cycle counter wrap
    wr(A_CCNT, 32'hFFFF_FFFE);
    wr(A_CTRL, 32'h1);
    idle(1);
    wr(A_CTRL, 32'h0);
    rd(A_CCNT, v); chk("R9 cycle wrapped", v, 32'h0);
    rd(A_FLAG, v); chk("R9 flag bits", v, 32'h9);

    // R10 write-one-to-clear
    wr(A_FLAG, 32'h0);
    rd(A_FLAG, v); chk("R10 zero write ignored", v, 32'h9);
    wr(A_FLAG, 32'h8);
    rd(A_FLAG, v); chk("R10 one clears", v, 32'h1);
    idle(1);
    chk("R11 irq drops with masked flag gone", {31'b0, irq}, 32'h0);

    // R11 mask change
    wr(A_IEN, 32'h1);
    chk("R11 irq one clock after mask", {31'b0, irq}, 32'h0);
    idle(1);
    chk("R11 irq from cycle flag", {31'b0, irq}, 32'h1);
    wr(A_FLAG, 32'h1);
    idle(1);
    chk("R11 irq cleared", {31'b0, irq}, 32'h0);

    // R12 read latency: value shown is pre-edge contents
    wr(A_CCNT, 32'hA5);
    rd(A_CCNT, v); chk("R12 registered read", v, 32'hA5);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule